// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 32-bit virtual address into a 36-bit physical address by reading a three-level page table out of memory. A request carries the virtual address, a write flag and the frame number of the requesting process's top-level table. The walker reads one 32-bit entry per level through a simple memory port. It checks each entry as it arrives and either stops with a fault or follows the frame number to the next table. A successful translation yields the final frame number joined with the page offset.

Each entry holds a 24-bit frame number in bits [31:8], a present flag in bit 0, a writable flag in bit 1 and a dirty flag in bit 2. Bits [7:3] are ignored. A write that reaches a leaf whose dirty flag is clear stores that entry back with the flag set before the result is reported. The result stays on the outputs until the requester acknowledges it.

Top module: `pt_walker`

## Requirements
- R1: The virtual address splits into bits [31:30] as the top-level index, bits [29:21] as the middle index, bits [20:12] as the leaf index and bits [11:0] as the offset. The entry read at each level sits at {table frame, index zero-extended to 10 bits, 2'b00}. The top-level table frame is `req_root`.
- R2: A walk issues exactly one read per level and holds `mem_req_valid`, `mem_addr` and `mem_req_write` steady until `mem_rsp_valid`.
- R3: A walk that finds every entry valid reports fault code 00 and `res_pa` = {leaf entry bits [31:8], offset}.
- R4: An entry with bit 0 clear ends the walk with fault code 01. `res_level` gives that level (0 top, 1 middle, 2 leaf), and no further read is made.
- R5: A write access that meets an entry with bit 1 clear at any level ends the walk with fault code 10, with `res_level` set to that level.
- R6: A successful write whose leaf entry has bit 2 clear performs one memory write of that entry with bit 2 set, to the leaf entry's address, before the result. Reads, and writes to an already-dirty leaf, perform no memory write.
- R7: A request is taken only while `req_ready` is high. `req_valid` during a walk or while a result is pending has no effect.
- R8: After reset, `req_ready` is high and `res_valid` and `mem_req_valid` are low. A result stays valid and unchanged until a cycle with `res_ack` high, after which `res_valid` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request taken |
| req_va | input | 32 | Virtual address |
| req_write | input | 1 | 1 = write access |
| req_root | input | 24 | Frame of the top-level table |
| mem_req_valid | output | 1 | Memory access pending |
| mem_req_write | output | 1 | 1 = write back of leaf entry |
| mem_addr | output | 36 | Byte address of the entry |
| mem_wdata | output | 32 | Entry written back |
| mem_rsp_valid | input | 1 | Memory access completed |
| mem_rdata | input | 32 | Entry read |
| res_valid | output | 1 | Result available |
| res_fault | output | 2 | 00 ok, 01 not present, 10 protection |
| res_level | output | 2 | Level at which a fault occurred |
| res_pa | output | 36 | Physical address (zero on fault) |
| res_ack | input | 1 | Result consumed |

## Verification
The bench goes after faults at each of the three levels. A walker that kept reading past a missing entry would show an extra read, and one that reported the wrong level would give a wrong `res_level`. It compares the addresses of all three reads against the index fields, because a field sliced one bit off lands on a neighbouring entry. It checks the dirty write-back from both sides: a walker that skipped it would leave the leaf clean, and one that always wrote would show a write on a read or on a second write. It also raises `req_valid` during a busy walk, where a walker that accepted it would restart or change its result.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int VA_W    = 32,
  parameter int FRAME_W = 24,
  parameter int OFF_W   = 12,
  parameter int IDX_W   = 9,
  parameter int TOP_W   = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [VA_W-1:0]          req_va,
  input  logic                     req_write,
  input  logic [FRAME_W-1:0]       req_root,
  output logic                     mem_req_valid,
  output logic                     mem_req_write,
  output logic [FRAME_W+OFF_W-1:0] mem_addr,
  output logic [31:0]              mem_wdata,
  input  logic                     mem_rsp_valid,
  input  logic [31:0]              mem_rdata,
  output logic                     res_valid,
  output logic [1:0]               res_fault,
  output logic [1:0]               res_level,
  output logic [FRAME_W+OFF_W-1:0] res_pa,
  input  logic                     res_ack
);
  localparam int SLOT_W = OFF_W - 2;
  localparam int LEAF_LO = OFF_W;
  localparam int MID_LO  = OFF_W + IDX_W;
  localparam int TOP_LO  = OFF_W + 2 * IDX_W;

  typedef enum logic [1:0] {S_IDLE, S_WALK, S_WB, S_DONE} st_t;
  localparam logic [1:0] F_OK = 2'b00, F_NP = 2'b01, F_PROT = 2'b10;

  st_t                st;
  logic [1:0]         lvl;
  logic [FRAME_W-1:0] frame;
  logic [VA_W-1:0]    va;
  logic               wr;
  logic [31:0]        ent;
  logic [1:0]         fault;
  logic [SLOT_W-1:0]  idx;

  always_comb begin
    case (lvl)
      2'd0:    idx = SLOT_W'(va[TOP_LO +: TOP_W]);
      2'd1:    idx = SLOT_W'(va[MID_LO +: IDX_W]);
      default: idx = SLOT_W'(va[LEAF_LO +: IDX_W]);
    endcase
  end

  assign req_ready     = (st == S_IDLE);
  assign mem_req_valid = (st == S_WALK) || (st == S_WB);
  assign mem_req_write = (st == S_WB);
  assign mem_addr      = {frame, idx, 2'b00};
  assign mem_wdata     = ent | 32'h4;
  assign res_valid     = (st == S_DONE);
  assign res_fault     = fault;
  assign res_level     = lvl;
  assign res_pa        = (fault == F_OK) ? {ent[31:32-FRAME_W], va[OFF_W-1:0]} : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      lvl   <= '0;
      frame <= '0;
      va    <= '0;
      wr    <= 1'b0;
      ent   <= '0;
      fault <= F_OK;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          va    <= req_va;
          wr    <= req_write;
          frame <= req_root;
          lvl   <= '0;
          fault <= F_OK;
          st    <= S_WALK;
        end
        S_WALK: if (mem_rsp_valid) begin
          ent <= mem_rdata;
          if (!mem_rdata[0]) begin
            fault <= F_NP;
            st    <= S_DONE;
          end else if (wr && !mem_rdata[1]) begin
            fault <= F_PROT;
            st    <= S_DONE;
          end else if (lvl == 2'd2) begin
            fault <= F_OK;
            st    <= (wr && !mem_rdata[2]) ? S_WB : S_DONE;
          end else begin
            frame <= mem_rdata[31:32-FRAME_W];
            lvl   <= lvl + 2'd1;
          end
        end
        S_WB: if (mem_rsp_valid) begin
          ent <= ent | 32'h4;
          st  <= S_DONE;
        end
        default: if (res_ack) st <= S_IDLE;
      endcase
    end
  end
endmodule

module pt_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic [31:0] req_va,
  input logic        req_write,
  input logic        mem_req_valid,
  input logic        mem_req_write,
  input logic [35:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic        mem_rsp_valid,
  input logic        res_valid,
  input logic [1:0]  res_fault,
  input logic [1:0]  res_level,
  input logic [35:0] res_pa,
  input logic        res_ack
);
  logic [31:0] va_q;
  logic        wr_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      va_q <= '0;
      wr_q <= 1'b0;
    end else if (req_valid && req_ready) begin
      va_q <= req_va;
      wr_q <= req_write;
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!mem_req_valid && !res_valid)); // R7
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_rsp_valid) |=> (mem_req_valid && $stable(mem_addr) && $stable(mem_req_write))); // R2
  AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ack) |=> (res_valid && $stable(res_pa) && $stable(res_fault) && $stable(res_level))); // R8
  AST_RES_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ack) |=> !res_valid); // R8
  AST_PA_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_fault == 2'b00) |-> (res_pa[11:0] == va_q[11:0])); // R3
  AST_WB_ONLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_write) |-> (wr_q && mem_wdata[2] && mem_wdata[0] && mem_wdata[1])); // R6
  AST_PROT_ONLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_fault == 2'b10) |-> wr_q); // R5
  AST_FAULT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_fault != 2'b11 && res_level != 2'b11)); // R4
endmodule

bind pt_walker pt_walker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_va(req_va), .req_write(req_write), .mem_req_valid(mem_req_valid),
  .mem_req_write(mem_req_write), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .mem_rsp_valid(mem_rsp_valid), .res_valid(res_valid), .res_fault(res_fault),
  .res_level(res_level), .res_pa(res_pa), .res_ack(res_ack)
);

// File: tb/pt_walker_tb.sv
module pt_walker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_va = '0;
  logic        req_write = 1'b0;
  logic [23:0] req_root = '0;
  logic        mem_req_valid, mem_req_write;
  logic [35:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        res_valid;
  logic [1:0]  res_fault, res_level;
  logic [35:0] res_pa;
  logic        res_ack = 1'b0;

  int checks = 0;
  int errors = 0;
  int nrd = 0;
  int nwr = 0;
  int wait_cnt = 0;
  logic [35:0] rd_addr [8];
  logic [35:0] wr_addr;
  logic [31:0] wr_data;
  logic [31:0] mem [logic [35:0]];
  logic [1:0]  got_fault, got_level;
  logic [35:0] got_pa;

  localparam logic [23:0] ROOT = 24'h000100;

  always #5 clk = ~clk;

  pt_walker u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_va(req_va), .req_write(req_write), .req_root(req_root),
    .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rdata(mem_rdata), .res_valid(res_valid), .res_fault(res_fault),
    .res_level(res_level), .res_pa(res_pa), .res_ack(res_ack)
  );

  initial begin
    forever begin
      @(negedge clk);
      if (mem_rsp_valid) mem_rsp_valid = 1'b0;
      else if (mem_req_valid) begin
        if (wait_cnt < 2) wait_cnt++;
        else begin
          wait_cnt = 0;
          if (mem_req_write) begin
            mem[mem_addr] = mem_wdata;
            wr_addr = mem_addr;
            wr_data = mem_wdata;
            nwr++;
          end else begin
            mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
            rd_addr[nrd % 8] = mem_addr;
            nrd++;
          end
          mem_rsp_valid = 1'b1;
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] pte(input logic [23:0] f, input bit w, input bit d, input bit p);
    return {f, 5'b0, d, w, p};
  endfunction

  function automatic logic [35:0] slot(input logic [23:0] tbl, input logic [9:0] i);
    return {tbl, i, 2'b00};
  endfunction

  task automatic start(input logic [31:0] va, input bit wr);
    nrd = 0; nwr = 0;
    @(negedge clk);
    req_valid = 1'b1; req_va = va; req_write = wr; req_root = ROOT;
    @(negedge clk);
  endtask

  task automatic finish_walk();
    int n = 0;
    while (!res_valid && n < 200) begin @(negedge clk); n++; end
    got_fault = res_fault; got_level = res_level; got_pa = res_pa;
  endtask

  task automatic ack_result(input string tag);
    repeat (2) @(negedge clk);
    chk({tag, " hold valid"}, res_valid, 1'b1);
    chk({tag, " hold pa"}, res_pa, got_pa);
    res_ack = 1'b1;
    @(negedge clk);
    res_ack = 1'b0;
    chk({tag, " release"}, res_valid, 1'b0);
  endtask

  task automatic run(input logic [31:0] va, input bit wr);
    start(va, wr);
    req_valid = 1'b0;
    finish_walk();
  endtask

  task automatic t_read_ok();
    run({2'd2, 9'h1A5, 9'h1FF, 12'hABC}, 1'b0);
    chk("R1 top slot", rd_addr[0], slot(ROOT, 10'd2));
    chk("R1 mid slot", rd_addr[1], slot(24'h000200, 10'h1A5));
    chk("R1 leaf slot", rd_addr[2], slot(24'h000300, 10'h1FF));
    chk("R2 read count", nrd, 3);
    chk("R3 fault", got_fault, 2'b00);
    chk("R3 pa", got_pa, {24'hABCDE0, 12'hABC});
    chk("R6 no write on read", nwr, 0);
    ack_result("R8 read");
  endtask

  task automatic t_prot_leaf();
    run({2'd2, 9'h1A5, 9'h1FF, 12'h004}, 1'b1);
    chk("R5 leaf fault", got_fault, 2'b10);
    chk("R5 leaf level", got_level, 2'd2);
    chk("R5 pa zero", got_pa, 36'h0);
    chk("R6 no write on prot", nwr, 0);
    ack_result("R8 prot");
  endtask

  task automatic t_write_dirty();
    run({2'd2, 9'h1A5, 9'h010, 12'h7F0}, 1'b1);
    chk("R3 write fault", got_fault, 2'b00);
    chk("R3 write pa", got_pa, {24'h123450, 12'h7F0});
    chk("R6 write count", nwr, 1);
    chk("R6 write addr", wr_addr, slot(24'h000300, 10'h010));
    chk("R6 write data", wr_data, pte(24'h123450, 1, 1, 1));
    ack_result("R8 dirty");
    run({2'd2, 9'h1A5, 9'h010, 12'h001}, 1'b1);
    chk("R6 already dirty no write", nwr, 0);
    chk("R2 dirty read count", nrd, 3);
    ack_result("R8 dirty2");
  endtask

  task automatic t_np_mid();
    run({2'd1, 9'h033, 9'h000, 12'h000}, 1'b0);
    chk("R4 mid fault", got_fault, 2'b01);
    chk("R4 mid level", got_level, 2'd1);
    chk("R4 mid reads", nrd, 2);
    ack_result("R8 np1");
  endtask

  task automatic t_np_top();
    run({2'd3, 9'h1A5, 9'h1FF, 12'h000}, 1'b0);
    chk("R4 top fault", got_fault, 2'b01);
    chk("R4 top level", got_level, 2'd0);
    chk("R4 top reads", nrd, 1);
    ack_result("R8 np0");
  endtask

  task automatic t_prot_top();
    run({2'd1, 9'h033, 9'h000, 12'h000}, 1'b1);
    chk("R5 top fault", got_fault, 2'b10);
    chk("R5 top level", got_level, 2'd0);
    chk("R5 top reads", nrd, 1);
    ack_result("R8 prot0");
  endtask

  task automatic t_busy_ignored();
    start({2'd2, 9'h1A5, 9'h1FF, 12'h123}, 1'b0);
    req_va = {2'd3, 9'h0, 9'h0, 12'h0};
    req_write = 1'b1;
    finish_walk();
    req_valid = 1'b0;
    chk("R7 busy fault", got_fault, 2'b00);
    chk("R7 busy pa", got_pa, {24'hABCDE0, 12'h123});
    chk("R7 busy reads", nrd, 3);
    ack_result("R7 busy");
    repeat (6) @(negedge clk);
    chk("R7 no restart", nrd, 3);
    chk("R7 idle", req_ready, 1'b1);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    mem[slot(ROOT, 10'd2)]             = pte(24'h000200, 1, 0, 1);
    mem[slot(24'h000200, 10'h1A5)]     = pte(24'h000300, 1, 0, 1);
    mem[slot(24'h000300, 10'h1FF)]     = pte(24'hABCDE0, 0, 0, 1);
    mem[slot(24'h000300, 10'h010)]     = pte(24'h123450, 1, 0, 1);
    mem[slot(ROOT, 10'd1)]             = pte(24'h000400, 0, 0, 1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 reset ready", req_ready, 1'b1);
    chk("R8 reset res", res_valid, 1'b0);
    chk("R8 reset mem", mem_req_valid, 1'b0);
    t_read_ok();
    t_prot_leaf();
    t_write_dirty();
    t_np_mid();
    t_np_top();
    t_prot_top();
    t_busy_ignored();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule